// File: doc/BRIEF.md
# Pseudo-Random Correlation Response Analyzer

This block runs a self-contained dynamic test of an analog path. It emits a two-level pseudo-random stimulus that behaves as digital white noise. The stimulus goes out to a converter, through the circuit under test, and comes back as digitized response samples. Over one test run the block averages, sample by sample, either the product of the response with a lagged copy of its own stimulus (cross-correlation) or the square of the response (auto-correlation).

Against a white-noise stimulus, the cross-correlation at lag m is proportional to the impulse-response tap h[m] of the path. Sweeping the lag over several runs therefore recovers the path's response. The auto-correlation gives its output power. Software pulses start with a mode and a lag. One response sample is consumed per clock while busy, and done rises with the averaged result, which is then held.

The run length is a power of two, so the final average is an arithmetic shift. The lagged stimulus comes from a short delay line that stores only the stimulus sign bit.

Top module: `prn_corr_analyzer`

## Requirements
- R1: After reset, busy_o and done_o are 0, stim_o is 0 and result_o is 0.
- R2: The stimulus generator is a 15-bit shift register with feedback polynomial x^15+x^14+1. The state shifts left by one each sample, and the new bit 0 is state[14] XOR state[13]. The state is loaded with 1 at start. While busy, stim_o is +AMP when state bit 14 is 1 and −AMP when it is 0. While idle, stim_o is 0.
- R3: In cross mode (mode_i = 0), result_o equals the sum of x[n−m]·y[n] over the accumulated samples, arithmetically shifted right by K (floor of the mean over 2^K samples).
- R4: In auto mode (mode_i = 1), result_o equals the sum of y[n]·y[n] over the accumulated samples, arithmetically shifted right by K. The lag still sets how many leading samples are skipped.
- R5: The lag m (0 to 31) is taken from lag_i at start. x[n−m] is the stimulus that was driven m samples earlier in the same run, and lag 0 uses the current stimulus.
- R6: The first m samples of a run are not accumulated. A run lasts m+2^K samples, and busy_o is high for exactly that many cycles, beginning in the cycle after start.
- R7: done_o rises in the cycle after the final sample. It stays high, with result_o unchanged, until the next start. resp_i is ignored while idle.
- R8: start_i clears the accumulator and sample count and begins a new run, even while busy. If start coincides with the final sample of a run, the restart wins and done_o stays low.
- R9: Changes to lag_i and mode_i after start have no effect on the current run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Single-cycle pulse that begins a run |
| mode_i | input | 1 | 0 cross-correlation, 1 auto-correlation (sampled at start) |
| lag_i | input | 5 | Stimulus lag m (sampled at start) |
| stim_o | output | DW (12) | Signed stimulus sample toward the converter |
| resp_i | input | DW (12) | Signed response sample for the current stimulus |
| busy_o | output | 1 | Run in progress; one sample consumed per cycle |
| done_o | output | 1 | Result valid and held |
| result_o | output | 2·DW (24) | Signed averaged correlation |

## Verification
Two events can land in the same cycle: the last accumulated sample of a run, which would raise done, and a new start. The bench steps a run to the exact cycle whose sample is the final one and pulses start there. It then checks that done never rises, that busy stays high, and that the new run's stimulus restarts from the seed. A second case aborts a run midway, and the bench judges the new result against a fresh reference that ignores everything accumulated before the restart.

// File: rtl/prn_corr_pkg.sv
package prn_corr_pkg;
  typedef enum logic {
    CORR_CROSS = 1'b0,
    CORR_AUTO  = 1'b1
  } corr_mode_e;
endpackage

// File: rtl/prn_lfsr.sv
// Fibonacci shift register, feedback from the two top stages.
module prn_lfsr #(
  parameter int W    = 15,
  parameter int SEED = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic adv,
  output logic bit_o
);
  logic [W-1:0] q, q_nxt;

  always_comb begin
    q_nxt = q;
    if (load)
      q_nxt = W'(SEED);
    else if (adv)
      q_nxt = {q[W-2:0], q[W-1] ^ q[W-2]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= W'(SEED);
    else        q <= q_nxt;
  end

  assign bit_o = q[W-1];
endmodule

// File: rtl/prn_tap_delay.sv
// Sign-bit delay line; tap 0 is the live bit, tap k the bit k samples ago.
module prn_tap_delay #(
  parameter int DEPTH = 32,
  localparam int LAG_W = $clog2(DEPTH),
  localparam int STG   = DEPTH - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             bit_in,
  input  logic [LAG_W-1:0] lag,
  output logic             tap_bit
);
  logic [STG-1:0]   dl, dl_nxt;
  logic [DEPTH-1:0] taps;

  always_comb begin
    dl_nxt = dl;
    if (shift_en)
      dl_nxt = {dl[STG-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dl <= '0;
    else        dl <= dl_nxt;
  end

  assign taps    = {dl, bit_in};
  assign tap_bit = taps[lag];
endmodule

// File: rtl/prn_mac.sv
// Signed multiply-accumulate; operand pair picked by the mode.
module prn_mac
  import prn_corr_pkg::*;
#(
  parameter int DW = 12,
  parameter int K  = 8,
  localparam int PW = 2 * DW,
  localparam int AW = PW + K
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 acc_en,
  input  corr_mode_e           mode,
  input  logic signed [DW-1:0] stim,
  input  logic signed [DW-1:0] resp,
  output logic signed [AW-1:0] acc_sum
);
  logic signed [DW-1:0] op_a;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] acc_q, acc_nxt;

  assign op_a    = (mode == CORR_AUTO) ? resp : stim;
  assign prod    = op_a * resp;
  assign acc_sum = acc_q + {{K{prod[PW-1]}}, prod};

  always_comb begin
    acc_nxt = acc_q;
    if (clr)
      acc_nxt = '0;
    else if (acc_en)
      acc_nxt = acc_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_nxt;
  end
endmodule

// File: rtl/prn_corr_analyzer.sv
module prn_corr_analyzer
  import prn_corr_pkg::*;
#(
  parameter int DW     = 12,
  parameter int AMP    = 64,
  parameter int K      = 8,
  parameter int DEPTH  = 32,
  parameter int LFSR_W = 15,
  parameter int SEED   = 1,
  localparam int LAG_W = $clog2(DEPTH),
  localparam int PW    = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 mode_i,
  input  logic [LAG_W-1:0]     lag_i,
  output logic signed [DW-1:0] stim_o,
  input  logic signed [DW-1:0] resp_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic signed [PW-1:0] result_o
);
  localparam int NSAMP = 1 << K;
  localparam int CNT_W = $clog2(DEPTH + NSAMP);
  localparam int AW    = PW + K;
  localparam logic signed [DW-1:0] LVL_P = DW'(AMP);
  localparam logic signed [DW-1:0] LVL_N = DW'(-AMP);

  // reset: asserted at once, released after two clocks
  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  logic             busy_q, busy_nxt;
  logic             done_q, done_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [LAG_W-1:0] lag_q, lag_nxt;
  corr_mode_e       mode_q, mode_nxt;
  logic [PW-1:0]    res_q, res_nxt;

  logic                 cur_bit, lag_bit, step, last, acc_en;
  logic signed [DW-1:0] lag_stim;
  logic signed [AW-1:0] acc_sum, acc_shr;

  assign step = busy_q && !start_i;
  assign last = busy_q && (cnt_q == CNT_W'(lag_q) + CNT_W'(NSAMP - 1));

  prn_lfsr #(.W(LFSR_W), .SEED(SEED)) i_lfsr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (start_i),
    .adv   (step),
    .bit_o (cur_bit)
  );

  prn_tap_delay #(.DEPTH(DEPTH)) i_delay (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .shift_en (step),
    .bit_in   (cur_bit),
    .lag      (lag_q),
    .tap_bit  (lag_bit)
  );

  assign lag_stim = lag_bit ? LVL_P : LVL_N;
  assign acc_en   = step && (cnt_q >= CNT_W'(lag_q));

  prn_mac #(.DW(DW), .K(K)) i_mac (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (start_i),
    .acc_en  (acc_en),
    .mode    (mode_q),
    .stim    (lag_stim),
    .resp    (resp_i),
    .acc_sum (acc_sum)
  );

  assign acc_shr = acc_sum >>> K;

  always_comb begin
    busy_nxt = busy_q;
    done_nxt = done_q;
    cnt_nxt  = cnt_q;
    lag_nxt  = lag_q;
    mode_nxt = mode_q;
    res_nxt  = res_q;
    if (start_i) begin
      busy_nxt = 1'b1;
      done_nxt = 1'b0;
      cnt_nxt  = '0;
      lag_nxt  = lag_i;
      mode_nxt = corr_mode_e'(mode_i);
    end else if (busy_q) begin
      cnt_nxt = cnt_q + 1'b1;
      if (last) begin
        busy_nxt = 1'b0;
        done_nxt = 1'b1;
        res_nxt  = acc_shr[PW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      lag_q  <= '0;
      mode_q <= CORR_CROSS;
      res_q  <= '0;
    end else begin
      busy_q <= busy_nxt;
      done_q <= done_nxt;
      cnt_q  <= cnt_nxt;
      lag_q  <= lag_nxt;
      mode_q <= mode_nxt;
      res_q  <= res_nxt;
    end
  end

  assign stim_o   = busy_q ? (cur_bit ? LVL_P : LVL_N) : '0;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign result_o = res_q;
endmodule

// File: rtl/prn_corr_checker.sv
module prn_corr_checker #(
  parameter int DW    = 12,
  parameter int AMP   = 64,
  parameter int K     = 8,
  parameter int DEPTH = 32,
  localparam int LAG_W = $clog2(DEPTH),
  localparam int PW    = 2 * DW
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start_i,
  input logic [LAG_W-1:0]     lag_i,
  input logic signed [DW-1:0] stim_o,
  input logic                 busy_o,
  input logic                 done_o,
  input logic signed [PW-1:0] result_o
);
  localparam int NSAMP = 1 << K;
  localparam logic signed [DW-1:0] LVL_P = DW'(AMP);
  localparam logic signed [DW-1:0] LVL_N = DW'(-AMP);

  int               run_cnt;
  logic [LAG_W-1:0] run_lag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= 0;
      run_lag <= '0;
    end else if (start_i) begin
      run_cnt <= 0;
      run_lag <= lag_i;
    end else if (busy_o) begin
      run_cnt <= run_cnt + 1;
    end
  end

  p_stim_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> stim_o == '0);
  p_stim_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (stim_o == LVL_P || stim_o == LVL_N));
  p_run_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> run_cnt == int'(run_lag) + NSAMP);
  p_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && busy_o));
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(done_o)) |-> $stable(result_o));
  p_done_on_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
  p_start_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (busy_o && !done_o));
endmodule

bind prn_corr_analyzer prn_corr_checker #(
  .DW(DW), .AMP(AMP), .K(K), .DEPTH(DEPTH)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .lag_i    (lag_i),
  .stim_o   (stim_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o)
);

// File: tb/test_prn_corr_analyzer.sv
module test_prn_corr_analyzer;
  localparam int DW = 12, AMP = 64, K = 8, NSAMP = 1 << K;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 start_i = 1'b0;
  logic                 mode_i = 1'b0;
  logic [4:0]           lag_i = '0;
  logic signed [DW-1:0] stim_o;
  logic signed [DW-1:0] resp_i = '0;
  logic                 busy_o, done_o;
  logic signed [2*DW-1:0] result_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  prn_corr_analyzer i_prn_corr_analyzer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .lag_i(lag_i), .stim_o(stim_o), .resp_i(resp_i), .busy_o(busy_o),
    .done_o(done_o), .result_o(result_o)
  );

  // behavioural reference
  bit     m_busy = 0, m_done = 0;
  int     m_cnt = 0, m_lag = 0, m_mode = 0, m_lfsr = 1;
  longint m_sum = 0, m_result = 0;
  int     xhist[$];

  function automatic int cur_x();
    if (!m_busy) return 0;
    return ((m_lfsr >> 14) & 1) ? AMP : -AMP;
  endfunction

  function automatic int past_x(int k);
    int n = xhist.size();
    if (k == 0) return cur_x();
    if (n - k < 0) return 0;
    return xhist[n - k];
  endfunction

  // path model: three-tap filter
  function automatic int path_y();
    if (!m_busy) return 77;
    return 3 * past_x(0) - 2 * past_x(1) + past_x(2);
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    if (start_i) begin
      m_busy = 1; m_done = 0; m_cnt = 0; m_sum = 0; m_lfsr = 1;
      m_lag = lag_i; m_mode = mode_i;
      xhist.delete();
    end else if (m_busy) begin
      int x = cur_x();
      int y = resp_i;
      longint p = (m_mode == 1) ? longint'(y) * y : longint'(past_x(m_lag)) * y;
      if (m_cnt >= m_lag) m_sum += p;
      if (m_cnt == m_lag + NSAMP - 1) begin
        m_busy = 0; m_done = 1; m_result = m_sum >>> K;
      end
      xhist.push_back(x);
      m_lfsr = ((m_lfsr << 1) | (((m_lfsr >> 14) ^ (m_lfsr >> 13)) & 1)) & 32'h7fff;
      m_cnt++;
    end
  endtask

  task automatic tick();
    model_edge();
    @(negedge clk);
    check("R2 stim", stim_o, cur_x());
    check("R6 busy", busy_o, m_busy);
    check("R7 done", done_o, m_done);
    if (m_done) check(m_mode ? "R4 result" : "R3 result", result_o, m_result);
    start_i = 1'b0;
    resp_i  = DW'(path_y());
  endtask

  task automatic go(int lag, int mode);
    start_i = 1'b1; lag_i = 5'(lag); mode_i = mode[0];
    tick();
    check("R8 start", {busy_o, done_o}, 2'b10);
    // R9: disturb the sampled controls during the run
    lag_i = 5'(lag + 7); mode_i = ~mode[0];
  endtask

  task automatic run_to_end();
    while (m_busy) tick();
  endtask

  task automatic run_to_last();
    while (!(m_busy && m_cnt == m_lag + NSAMP - 1)) tick();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      lag_i = 5'(i); mode_i = i[0];
      tick();
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check("R1 busy", busy_o, 0);
        check("R1 done", done_o, 0);
        check("R1 stim", stim_o, 0);
        check("R1 result", result_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        resp_i = DW'(77);
        idle(2);
        // R3 and R5: lag sweep in cross mode
        go(0, 0);  run_to_end(); check("R5 lag0", result_o, m_result); idle(4);
        go(1, 0);  run_to_end(); check("R5 lag1", result_o, m_result); idle(3);
        go(5, 0);  run_to_end(); check("R5 lag5", result_o, m_result); idle(3);
        go(31, 0); run_to_end(); check("R6 lag31", result_o, m_result); idle(3);
        // R4: auto mode with a lag skip
        go(3, 1);  run_to_end(); check("R4 auto", result_o, m_result); idle(5);
        // R8: abort mid-run
        go(2, 0);
        for (int i = 0; i < 50; i++) tick();
        go(4, 0);  run_to_end(); check("R8 abort", result_o, m_result); idle(2);
        // R8: restart on the final sample
        go(6, 1);  run_to_last();
        go(1, 0);
        check("R8 collide", done_o, 0);
        run_to_end(); check("R9 result", result_o, m_result);
        idle(4);
        check("R7 hold", result_o, m_result);
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected finish");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule